// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds wall-clock time and date as packed BCD registers. It keeps seconds, minutes, hours, day of month, month, a two-digit year and a three-bit day-of-week count. A one-cycle `tick` pulse, supplied once per second by an external prescaler, advances the time. Carries ripple through all fields in the same clock cycle, so every field is consistent in the cycle after the tick.

The hour register selects 24-hour or 12-hour operation through its top bit. In 12-hour mode, bit 5 marks afternoon. Month ends follow the calendar: 30 or 31 days, and 28 or 29 days in February. A year counts as a leap year when its two-digit value is a multiple of four. No century correction is applied, so year 00 is a leap year.

The host can overwrite any subset of fields through a one-hot load-select vector with a shared data byte. A load beats a tick that arrives in the same cycle. All outputs come straight from registers.

Top module: `cal_counter`

## Requirements
- R1: Seconds and minutes count 00 to 59 in BCD. A step past 59 returns the field to 00 and carries into the next field.
- R2: When hour bit 7 is 1, the hour field counts 00 to 23 in BCD in bits 5:0, and bit 6 reads 0. A step past 23 returns the field to 00 and advances the date.
- R3: When hour bit 7 is 0, bits 4:0 hold the hour 01 to 12 in BCD and bit 5 is the PM flag (1 = PM). Bit 6 reads 0. A step from 11 to 12 toggles PM, and a step from 12 to 01 leaves PM unchanged. The date advances only on the step from 11 PM to 12 AM.
- R4: Months 04, 06, 09 and 11 end after day 30, and months 01, 03, 05, 07, 08, 10 and 12 end after day 31. A step past the last day sets the date to 01 and advances the month.
- R5: February ends after day 29 when the binary value of the two-digit year is divisible by 4, including year 00. Otherwise it ends after day 28.
- R6: A step past month 12 sets the month to 01 and advances the year. Year 99 steps to 00.
- R7: The day of week is a 3-bit count 0,1,...,6,0. It advances exactly on the tick that changes the date.
- R8: After reset the outputs read: seconds 00, minutes 00, hour 0x12 (12-hour mode, AM, 12), date 01, month 01, year 00, day of week 0.
- R9: Bit i of `ld_sel` writes `ld_data` into a field on the next clock edge. The bit order is 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 day of week (`ld_data[2:0]`). The hour byte uses the layout of R2 and R3.
- R10: If any `ld_sel` bit is set, a tick in the same cycle is dropped. Unloaded fields keep their values.
- R11: With `tick` low and `ld_sel` zero, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per second |
| ld_sel | input | 7 | One-hot-per-field load strobes |
| ld_data | input | 8 | Load value shared by all fields |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Mode bit, PM bit and BCD hour |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| dow_o | output | 3 | Day of week, 0 to 6 |

## Verification
A corrupted carry or limit register shows at the ports in the cycle right after the offending tick. Typical symptoms are a field reading an illegal BCD code, a date past its month's end, or a higher field failing to move on a rollover. The sweeps therefore compare every output after every single tick against an arithmetic model. The hour sweeps place the clock at minute 59, second 59 before each tick, so every hour transition in both modes is reached within one cycle. The month sweeps load the last two days of every month for leap, non-leap and century years, so a wrong month length shows up as a date mismatch on the very next tick.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int BCD_W   = 8;
    localparam int FIELD_N = 7;

    typedef logic [BCD_W-1:0] bcd8_t;

    typedef enum logic [2:0] {
        F_SEC   = 3'd0,
        F_MIN   = 3'd1,
        F_HOUR  = 3'd2,
        F_DATE  = 3'd3,
        F_MONTH = 3'd4,
        F_YEAR  = 3'd5,
        F_DOW   = 3'd6
    } field_e;

    typedef struct packed {
        logic       mil;
        logic       pm;
        logic [5:0] hr;
    } hour_t;

    function automatic bcd8_t bcd_inc(input bcd8_t v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_to_bin(input bcd8_t v);
        return ({3'b0, v[7:4]} * 7'd10) + {3'b0, v[3:0]};
    endfunction

    function automatic logic year_is_leap(input bcd8_t yr);
        logic [6:0] b;
        b = bcd_to_bin(yr);
        return (b[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
    import cal_pkg::*;
(
    input  bcd8_t month,
    input  bcd8_t year,
    output bcd8_t last_day
);
    always_comb begin
        unique case (month)
            8'h02:                      last_day = year_is_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
    import cal_pkg::*;
#(
    parameter bcd8_t RST_VAL  = 8'h00,
    parameter bcd8_t WRAP_VAL = 8'h00
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  logic  load,
    input  bcd8_t load_val,
    input  bcd8_t top_val,
    output bcd8_t value,
    output logic  carry
);
    logic at_top;

    assign at_top = (value >= top_val);
    assign carry  = step & at_top;

    always_ff @(posedge clk) begin
        if (rst)
            value <= RST_VAL;
        else if (load)
            value <= load_val;
        else if (step)
            value <= at_top ? WRAP_VAL : bcd_inc(value);
    end
endmodule

// File: rtl/cal_hour_unit.sv
module cal_hour_unit
    import cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  logic  load,
    input  bcd8_t load_val,
    output bcd8_t hour_reg,
    output logic  carry
);
    hour_t st;
    bcd8_t hr_next;
    logic  day_end;

    assign hr_next = bcd_inc({2'b00, st.hr});
    assign day_end = st.mil ? (st.hr >= 6'h23) : ((st.hr == 6'h11) && st.pm);
    assign carry   = step & day_end;

    assign hour_reg = st.mil ? {1'b1, 1'b0, st.hr}
                             : {1'b0, 1'b0, st.pm, st.hr[4:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{mil: 1'b0, pm: 1'b0, hr: 6'h12};
        end else if (load) begin
            st.mil <= load_val[7];
            if (load_val[7]) begin
                st.pm <= 1'b0;
                st.hr <= load_val[5:0];
            end else begin
                st.pm <= load_val[5];
                st.hr <= {1'b0, load_val[4:0]};
            end
        end else if (step) begin
            if (st.mil) begin
                st.hr <= (st.hr >= 6'h23) ? 6'h00 : hr_next[5:0];
            end else if (st.hr >= 6'h12) begin
                st.hr <= 6'h01;
            end else if (st.hr == 6'h11) begin
                st.hr <= 6'h12;
                st.pm <= ~st.pm;
            end else begin
                st.hr <= hr_next[5:0];
            end
        end
    end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
    import cal_pkg::*;
#(
    parameter int DOW_W    = 3,
    parameter int DOW_DAYS = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [FIELD_N-1:0] ld_sel,
    input  logic [BCD_W-1:0]   ld_data,
    output logic [BCD_W-1:0]   sec_o,
    output logic [BCD_W-1:0]   min_o,
    output logic [BCD_W-1:0]   hour_o,
    output logic [BCD_W-1:0]   date_o,
    output logic [BCD_W-1:0]   month_o,
    output logic [BCD_W-1:0]   year_o,
    output logic [DOW_W-1:0]   dow_o
);
    localparam logic [DOW_W-1:0] DOW_LAST = DOW_W'(DOW_DAYS - 1);

    logic  adv;
    logic  sec_c, min_c, hour_c, date_c, month_c, year_c;
    bcd8_t last_day;

    // a host write pre-empts the tick for the whole register set
    assign adv = tick & ~(|ld_sel);

    cal_bcd_field #(.RST_VAL(8'h00), .WRAP_VAL(8'h00)) u_sec (
        .clk(clk), .rst(rst), .step(adv), .load(ld_sel[F_SEC]),
        .load_val(ld_data), .top_val(8'h59), .value(sec_o), .carry(sec_c));

    cal_bcd_field #(.RST_VAL(8'h00), .WRAP_VAL(8'h00)) u_min (
        .clk(clk), .rst(rst), .step(sec_c), .load(ld_sel[F_MIN]),
        .load_val(ld_data), .top_val(8'h59), .value(min_o), .carry(min_c));

    cal_hour_unit u_hour (
        .clk(clk), .rst(rst), .step(min_c), .load(ld_sel[F_HOUR]),
        .load_val(ld_data), .hour_reg(hour_o), .carry(hour_c));

    cal_month_len u_mlen (
        .month(month_o), .year(year_o), .last_day(last_day));

    cal_bcd_field #(.RST_VAL(8'h01), .WRAP_VAL(8'h01)) u_date (
        .clk(clk), .rst(rst), .step(hour_c), .load(ld_sel[F_DATE]),
        .load_val(ld_data), .top_val(last_day), .value(date_o), .carry(date_c));

    cal_bcd_field #(.RST_VAL(8'h01), .WRAP_VAL(8'h01)) u_month (
        .clk(clk), .rst(rst), .step(date_c), .load(ld_sel[F_MONTH]),
        .load_val(ld_data), .top_val(8'h12), .value(month_o), .carry(month_c));

    cal_bcd_field #(.RST_VAL(8'h00), .WRAP_VAL(8'h00)) u_year (
        .clk(clk), .rst(rst), .step(month_c), .load(ld_sel[F_YEAR]),
        .load_val(ld_data), .top_val(8'h99), .value(year_o), .carry(year_c));

    always_ff @(posedge clk) begin
        if (rst)
            dow_o <= '0;
        else if (ld_sel[F_DOW])
            dow_o <= ld_data[DOW_W-1:0];
        else if (hour_c)
            dow_o <= (dow_o >= DOW_LAST) ? '0 : dow_o + 1'b1;
    end

    logic unused_c;
    assign unused_c = year_c;
endmodule

// File: rtl/cal_counter_chk.sv
module cal_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [6:0] ld_sel,
    input logic [7:0] ld_data,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic [2:0] dow_o
);
    logic midnight;
    assign midnight = (sec_o == 8'h59) && (min_o == 8'h59) &&
                      ((hour_o == 8'hA3) || (hour_o == 8'h31));

    // R1
    sec_bcd_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_o[3:0] <= 4'd9) && (sec_o <= 8'h59));

    // R3
    hour12_range_chk: assert property (@(posedge clk) disable iff (rst)
        !hour_o[7] |-> (!hour_o[6] && hour_o[4:0] != 5'h00 && hour_o[4:0] <= 5'h12));

    // R7
    dow_range_chk: assert property (@(posedge clk) disable iff (rst)
        dow_o != 3'd7);

    // R7
    midnight_roll_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ld_sel == 7'd0 && midnight) |=>
        (dow_o != $past(dow_o)) && (date_o != $past(date_o)));

    // R9
    sec_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld_sel[0] |=> sec_o == $past(ld_data));

    // R10
    tick_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ld_sel != 7'd0 && !ld_sel[0]) |=> $stable(sec_o));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && ld_sel == 7'd0) |=>
        ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(date_o)
         && $stable(month_o) && $stable(year_o) && $stable(dow_o)));
endmodule

bind cal_counter cal_counter_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .ld_sel(ld_sel), .ld_data(ld_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
    .month_o(month_o), .year_o(year_o), .dow_o(dow_o));

// File: tb/cal_counter_test.sv
module cal_counter_test;
    logic       clk = 1'b0;
    logic       rst, tick;
    logic [6:0] ld_sel;
    logic [7:0] ld_data;
    logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
    logic [2:0] dow_o;

    always #4 clk = ~clk;

    cal_counter uut (
        .clk(clk), .rst(rst), .tick(tick), .ld_sel(ld_sel), .ld_data(ld_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
        .month_o(month_o), .year_o(year_o), .dow_o(dow_o));

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // reference model in plain integers, hour kept as 0..23
    int s, m, h, mil, d, mo, y, dw;

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int unbcd(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic int dim(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] exp_hour();
        int h12;
        if (mil != 0) return 8'h80 | bcd(h);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return ((h >= 12) ? 8'h20 : 8'h00) | bcd(h12);
    endfunction

    task automatic model_reset();
        s = 0; m = 0; h = 0; mil = 0; d = 1; mo = 1; y = 0; dw = 0;
    endtask

    task automatic model_tick();
        s++;
        if (s == 60) begin
            s = 0; m++;
            if (m == 60) begin
                m = 0; h++;
                if (h == 24) begin
                    h = 0; dw = (dw + 1) % 7; d++;
                    if (d > dim(mo, y)) begin
                        d = 1; mo++;
                        if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic model_load(input logic [6:0] sel, input logic [7:0] v);
        if (sel[0]) s = unbcd(v);
        if (sel[1]) m = unbcd(v);
        if (sel[2]) begin
            mil = int'(v[7]);
            if (v[7]) h = unbcd({2'b00, v[5:0]});
            else h = (unbcd({3'b000, v[4:0]}) % 12) + (v[5] ? 12 : 0);
        end
        if (sel[3]) d = unbcd(v);
        if (sel[4]) mo = unbcd(v);
        if (sel[5]) y = unbcd(v);
        if (sel[6]) dw = int'(v[2:0]);
    endtask

    task automatic check_all(input string tag);
        logic [50:0] got, exp;
        got = {sec_o, min_o, hour_o, date_o, month_o, year_o, dow_o};
        exp = {bcd(s), bcd(m), exp_hour(), bcd(d), bcd(mo), bcd(y), 3'(dw)};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one clock cycle: drive at negedge, registers move at posedge, sample at next negedge
    task automatic cyc(input bit t, input logic [6:0] sel, input logic [7:0] v);
        tick = t; ld_sel = sel; ld_data = v;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; ld_sel = '0; ld_data = '0;
        if (sel != 0) model_load(sel, v);
        else if (t) model_tick();
    endtask

    task automatic do_tick(input string tag);
        cyc(1'b1, 7'd0, 8'h00);
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b0; ld_sel = '0; ld_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R8");

        // R11: idle cycles change nothing
        repeat (5) cyc(1'b0, 7'd0, 8'h00);
        check_all("R11");

        // R1: seconds/minutes sweep across an hour boundary
        repeat (3700) do_tick("R1");

        // R3: every hour step in 12-hour mode over two days
        for (int i = 0; i < 48; i++) begin
            cyc(1'b0, 7'b0000011, 8'h59);
            do_tick("R3");
        end

        // R2: every hour step in 24-hour mode over two days
        cyc(1'b0, 7'b0000100, 8'h80);
        check_all("R2");
        for (int i = 0; i < 48; i++) begin
            cyc(1'b0, 7'b0000011, 8'h59);
            do_tick("R2");
        end

        // R9: individual field loads
        cyc(1'b0, 7'b0000001, 8'h37); check_all("R9");
        cyc(1'b0, 7'b0000010, 8'h14); check_all("R9");
        cyc(1'b0, 7'b0000100, 8'h92); check_all("R9");
        cyc(1'b0, 7'b0000100, 8'h27); check_all("R9");
        cyc(1'b0, 7'b0001000, 8'h15); check_all("R9");
        cyc(1'b0, 7'b0010000, 8'h07); check_all("R9");
        cyc(1'b0, 7'b0100000, 8'h42); check_all("R9");
        cyc(1'b0, 7'b1000000, 8'h05); check_all("R9");

        // R10: a load drops a coincident tick
        cyc(1'b1, 7'b0000010, 8'h20); check_all("R10");
        cyc(1'b1, 7'b0000001, 8'h10); check_all("R10");

        // R4, R5, R6: last two days of every month for several years
        begin
            int yrs[5] = '{0, 1, 2, 4, 99};
            for (int yi = 0; yi < 5; yi++) begin
                for (int mon = 1; mon <= 12; mon++) begin
                    cyc(1'b0, 7'b0100000, bcd(yrs[yi]));
                    cyc(1'b0, 7'b0010000, bcd(mon));
                    cyc(1'b0, 7'b0001000, bcd(dim(mon, yrs[yi]) - 1));
                    cyc(1'b0, 7'b0000100, 8'hA3);
                    cyc(1'b0, 7'b0000011, 8'h59);
                    do_tick(mon == 2 ? "R5" : "R4");
                    cyc(1'b0, 7'b0000100, 8'hA3);
                    cyc(1'b0, 7'b0000011, 8'h59);
                    do_tick(mon == 12 ? "R6" : (mon == 2 ? "R5" : "R4"));
                end
            end
        end

        // R7: day of week wraps 6 -> 0 at midnight (12-hour mode 11 PM)
        cyc(1'b0, 7'b1000000, 8'h06);
        cyc(1'b0, 7'b0000100, 8'h31);
        cyc(1'b0, 7'b0000011, 8'h59);
        do_tick("R7");
        for (int i = 0; i < 8; i++) begin
            cyc(1'b0, 7'b0000100, 8'hA3);
            cyc(1'b0, 7'b0000011, 8'h59);
            do_tick("R7");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule